// File: doc/BRIEF.md
# Parallel Vertical-Counter Switch Debouncer

The block filters a vector of mechanical switch inputs. Every lane is handled at the same time with bitwise logic. Each raw input first passes through a multi-flop synchroniser. A prescaler then produces a sample strobe once every `TICK_CYCLES` clocks, so that one sample can span several milliseconds.

Each lane has a 2-bit cyclic counter. The counter bits are not kept per lane. They are held in two shared words: a high-bit plane and a low-bit plane. On each strobe the block compares the synchronised sample with the filtered state and advances every counter with XOR/NOT logic. It then masks each counter with the difference, so a lane whose sample matches its filtered value falls back to zero. A lane's filtered bit toggles when its counter wraps back to zero while the difference is still present. That happens on the fourth consecutive differing sample.

The block has three outputs:
- the filtered vector;
- a change mask that pulses for one clock on the sample where a lane toggles;
- a flag that is high whenever any filtered lane differs from the idle level.

Top module: `sw_debounce_vc`

## Requirements
- R1: While reset is asserted, the filtered output equals `IDLE_LEVEL` (all ones by default), the change mask is all zero and the activity flag is 0.
- R2: A raw input change is seen by the filter only after it has passed through `SYNC_STAGES` flops. The filter state moves only on a strobe, which occurs on every `TICK_CYCLES`-th rising edge after reset is released. Between strobes the filtered output holds.
- R3: A lane's filtered bit toggles on the fourth consecutive strobe whose sample differs from it. The first three differing samples leave it unchanged.
- R4: A run of 1, 2 or 3 differing samples followed by a sample equal to the filtered value leaves the filtered bit unchanged and restarts the count, so a later change again needs four differing samples.
- R5: Bit i of the change mask is 1 for exactly the one clock after the strobe edge on which filtered bit i toggles, and is 0 at all other times.
- R6: Lanes are independent. With the filtered value 0xF0 and a steady input of 0x0F, all eight lanes toggle on the same fourth strobe, giving 0x0F and a change mask of 0xFF.
- R7: The activity flag is 1 exactly when the filtered output differs from `IDLE_LEVEL` in at least one bit.
- R8: An input held equal to the filtered value never changes the output and never raises a change-mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_raw | input | LANES | Unsynchronised switch levels, bit i is lane i |
| db_out | output | LANES | Filtered switch levels |
| db_chg | output | LANES | One-clock pulse per lane on the sample where that lane toggles |
| any_active | output | 1 | High when any filtered lane differs from the idle level |

## Verification
The bench aligns input changes to the strobe so that it controls exactly how many samples see each level.

It drives glitches of one, two and three samples:
- A counter that is not cleared on return would let a later short run complete a stale count and flip early.
- An off-by-one in the wrap would flip on the third or fifth sample.

It moves all lanes together from 0xF0 to 0x0F. A design that shares state between lanes would toggle some lanes late or produce a partial mask.

It also checks that the mask pulse lasts one clock, and that nothing moves between strobes. A mask held for a whole sample period, or a filter clocked every cycle, breaks these checks.

// File: rtl/dbv_pkg.sv
package dbv_pkg;
   // Width of a counter that must hold values 0 .. n-1 (never less than 1)
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dbv_sync.sv
module dbv_sync #(
   parameter int unsigned       W       = 8,
   parameter int unsigned       STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbv_tick.sv
module dbv_tick #(
   parameter int unsigned PERIOD = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = dbv_pkg::cnt_bits(PERIOD);

   generate
      if (PERIOD <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         logic [CW-1:0] cnt;
         localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/dbv_vcount.sv
module dbv_vcount #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] INIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] samp,
   output logic [W-1:0] db,
   output logic [W-1:0] chg,
   output logic [W-1:0] cnt_hi,
   output logic [W-1:0] cnt_lo
);
   logic [W-1:0] hi_q, lo_q, db_q, chg_q;
   logic [W-1:0] diff, hi_n, lo_n, flip;

   always_comb begin
      diff = samp ^ db_q;
      // cyclic 2-bit step on every lane, then clear lanes that agree
      hi_n = (hi_q ^ lo_q) & diff;
      lo_n = ~lo_q & diff;
      // wrapped to zero while still differing -> accept new level
      flip = ~(~diff | hi_n | lo_n);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         db_q  <= INIT;
         chg_q <= '0;
      end else if (tick) begin
         hi_q  <= hi_n;
         lo_q  <= lo_n;
         db_q  <= db_q ^ flip;
         chg_q <= flip;
      end else begin
         chg_q <= '0;
      end
   end

   assign db     = db_q;
   assign chg    = chg_q;
   assign cnt_hi = hi_q;
   assign cnt_lo = lo_q;
endmodule

// File: rtl/sw_debounce_vc.sv
module sw_debounce_vc #(
   parameter int unsigned      LANES       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      TICK_CYCLES = 100000,
   parameter logic [LANES-1:0] IDLE_LEVEL  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] sw_raw,
   output logic [LANES-1:0] db_out,
   output logic [LANES-1:0] db_chg,
   output logic             any_active
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("sw_debounce_vc: LANES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sw_debounce_vc: SYNC_STAGES must be at least 2");
      end
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("sw_debounce_vc: TICK_CYCLES must be at least 1");
      end
   endgenerate

   logic             tick_w;
   logic [LANES-1:0] samp_w, hi_w, lo_w;

   dbv_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sw_raw), .q(samp_w));

   dbv_tick #(.PERIOD(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick_w));

   dbv_vcount #(.W(LANES), .INIT(IDLE_LEVEL)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .samp(samp_w),
      .db(db_out), .chg(db_chg), .cnt_hi(hi_w), .cnt_lo(lo_w));

   assign any_active = |(db_out ^ IDLE_LEVEL);
endmodule

// File: rtl/dbv_chk.sv
module dbv_chk #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] IDLE = '1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic [W-1:0] samp,
   input logic [W-1:0] cnt_hi,
   input logic [W-1:0] cnt_lo,
   input logic [W-1:0] db_out,
   input logic [W-1:0] db_chg,
   input logic         any_active
);
   // R2: filtered output holds unless the previous edge carried a strobe
   p_hold_off_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(db_out));

   // R4: lanes whose sample matched at the strobe restart at zero
   p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> (((cnt_hi | cnt_lo) & ~$past(samp ^ db_out)) == '0));

   // R3: a toggle is only allowed from the last counter state
   p_flip_from_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> ((db_chg & ~($past(cnt_hi) & $past(cnt_lo))) == '0));

   // R5: output moves exactly by the reported mask
   p_mask_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (db_out == ($past(db_out) ^ db_chg)));

   // R7: activity flag agrees with the idle comparison
   p_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      any_active == (db_out != IDLE));
endmodule

bind sw_debounce_vc dbv_chk #(.W(LANES), .IDLE(IDLE_LEVEL)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_w), .samp(samp_w),
   .cnt_hi(hi_w), .cnt_lo(lo_w), .db_out(db_out), .db_chg(db_chg),
   .any_active(any_active));

// File: tb/test_sw_debounce_vc.sv
`timescale 1ns/1ps
module test_sw_debounce_vc;
   localparam int DIV = 3;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sw_raw = 8'hFF;
   logic [7:0] db_out, db_chg;
   logic       any_active;

   int checks = 0, fails = 0;
   bit done = 0;

   sw_debounce_vc #(.LANES(8), .SYNC_STAGES(2), .TICK_CYCLES(DIV), .IDLE_LEVEL(8'hFF))
      i_sw_debounce_vc (.clk(clk), .rst_n(rst_n), .sw_raw(sw_raw),
                        .db_out(db_out), .db_chg(db_chg), .any_active(any_active));

   always #2.5 clk = ~clk;

   // behavioural reference
   int         lane_cnt [8];
   logic [7:0] m_db, m_chg, m_s1, m_s2;
   int         m_pc;
   bit         last_tk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_db = 8'hFF; m_chg = 8'h00; m_s1 = 8'hFF; m_s2 = 8'hFF;
         m_pc = 0; last_tk = 0;
         for (int i = 0; i < 8; i++) lane_cnt[i] = 0;
      end else begin
         last_tk = (m_pc == DIV - 1);
         m_chg = 8'h00;
         if (last_tk) begin
            for (int i = 0; i < 8; i++) begin
               if (m_s2[i] != m_db[i]) begin
                  lane_cnt[i] = (lane_cnt[i] + 1) % 4;
                  if (lane_cnt[i] == 0) m_chg[i] = 1'b1;
               end else begin
                  lane_cnt[i] = 0;
               end
            end
            m_db = m_db ^ m_chg;
         end
         m_pc = last_tk ? 0 : m_pc + 1;
         m_s2 = m_s1;
         m_s1 = sw_raw;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (db_out !== m_db || db_chg !== m_chg || any_active !== (m_db != 8'hFF)) begin
            fails++;
            $display("FAIL R2 R3 R5 R7 model: got db=%h chg=%h act=%b exp db=%h chg=%h act=%b",
                     db_out, db_chg, any_active, m_db, m_chg, (m_db != 8'hFF));
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h exp %h", req, got, exp);
      end
   endtask

   task automatic after_tick();
      do @(negedge clk); while (!last_tk);
   endtask

   task automatic hold(input logic [7:0] v, input int n);
      sw_raw = v;
      repeat (n) after_tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset db", db_out, 8'hFF);
      chk("R1 reset chg", db_chg, 8'h00);
      chk("R1 reset active", {7'd0, any_active}, 8'h00);
      rst_n = 1'b1;
      after_tick();
      hold(8'hFF, 3);
      chk("R8 steady idle", db_out, 8'hFF);
      // single lane press
      hold(8'hFE, 3);
      chk("R3 three samples no flip", db_out, 8'hFF);
      hold(8'hFE, 1);
      chk("R3 fourth sample flips", db_out, 8'hFE);
      chk("R5 mask pulse", db_chg, 8'h01);
      chk("R7 active on press", {7'd0, any_active}, 8'h01);
      @(negedge clk);
      chk("R5 mask one clock", db_chg, 8'h00);
      hold(8'hFE, 2);
      chk("R8 steady pressed", db_out, 8'hFE);
      // glitches
      hold(8'hFF, 1); hold(8'hFE, 1);
      chk("R4 one sample glitch", db_out, 8'hFE);
      hold(8'hFF, 2); hold(8'hFE, 1);
      chk("R4 two sample glitch", db_out, 8'hFE);
      hold(8'hFF, 3); hold(8'hFE, 1);
      chk("R4 three sample glitch", db_out, 8'hFE);
      hold(8'hFF, 3);
      chk("R4 count restarted", db_out, 8'hFE);
      hold(8'hFF, 1);
      chk("R3 release accepted", db_out, 8'hFF);
      chk("R5 release mask", db_chg, 8'h01);
      // multi-lane
      hold(8'hF0, 4);
      chk("R6 to F0", db_out, 8'hF0);
      hold(8'h0F, 3);
      chk("R6 all counting", db_out, 8'hF0);
      hold(8'h0F, 1);
      chk("R6 all flip", db_out, 8'h0F);
      chk("R6 full mask", db_chg, 8'hFF);
      // R2: change between strobes is not visible before next strobe
      after_tick();
      sw_raw = 8'hFF;
      @(negedge clk);
      chk("R2 hold between strobes", db_out, 8'h0F);
      repeat (4) after_tick();
      chk("R7 back to idle", {7'd0, any_active}, 8'h00);
      repeat (5) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule